// File: doc/BRIEF.md
# Postfix Boolean Equation Evaluator

This block evaluates a stored program of single-bit logic equations written in postfix (reverse Polish) form. A sequencer walks the program memory from address zero upward and handles one entry per clock. Operand entries push a flag onto a 16-deep bit stack. The flag comes either from an external input vector or from the block's own virtual output bank. Operator entries pop their operands and push one result. An assignment entry pops the top of stack into one virtual output. Stateful operators are a set/reset latch and a pickup/dropout timer. Each keeps private per-instance state across passes.

A periodic pass-start strobe begins each pass, and a one-cycle done pulse ends it. The strobe is normally issued several times per power-frequency cycle. All assignments made during a pass land in a working copy. That copy is committed to the output port together with the done pulse. An equation that reads a virtual output before the program reassigns it therefore sees last pass's value. An equation that reads it after the reassignment sees the new value. Stack misuse raises a sticky error flag and discards the outputs of the faulty pass. The program is loaded through a plain write port, and timer delays through a second small write port.

Top module: `logic_eqn_engine`

## Requirements
- R1: Each program entry is 16 bits: opcode in bits [15:12], operand count in [11:8], index in [7:0]. After an accepted pass_start, entries are executed one per clock in ascending address order. The pass ends on opcode 0 (end), or after the last address. busy is high for exactly one cycle per executed entry, the end entry included, and pass_done then pulses for one cycle.
- R2: Opcode 1 pushes in_flags[index]. Opcode 2 pushes the current working value of virtual output [index].
- R3: Opcodes 4, 5 and 6 pop count operands and push their AND, OR or XOR (odd parity) respectively.
- R4: Opcode 3 (NOT) replaces the top of stack with its inverse.
- R5: Opcode 9 pops the top of stack into virtual output [index]. The vout port changes only in the cycle in which pass_done is high.
- R6: A virtual output read before its assignment in a pass yields the previous pass's value. A read after the assignment yields the newly assigned value.
- R7: Opcode 7 (latch, instance = index) pops reset (top) and set (below it) and pushes the stored bit. Reset dominates, set alone stores 1, and neither holds the stored bit from earlier passes.
- R8: Opcode 8 (timer, instance = index) pops one input and pushes its output. The output rises on the pickup-th consecutive pass with the input high. It falls on the dropout-th consecutive pass with the input low. The delays are written through the timer configuration port.
- R9: Stack underflow (including an operator with count 0), a push onto a full 16-entry stack, or a non-empty stack at the end of a pass sets err_flag. err_flag stays set until reset.
- R10: A pass in which any R9 condition occurs leaves vout unchanged. A later clean pass commits normally.
- R11: A pass_start that arrives while busy is high is ignored.
- R12: After reset, vout, busy, pass_done and err_flag are low, and every latch and timer output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| prog_we | input | 1 | Program memory write strobe |
| prog_addr | input | 6 | Program write address (PROG_DEPTH=64) |
| prog_data | input | 16 | Program entry to write |
| tcfg_we | input | 1 | Timer delay write strobe |
| tcfg_sel | input | 8 | Timer instance to configure |
| tcfg_pickup | input | 8 | Pickup delay in passes |
| tcfg_dropout | input | 8 | Dropout delay in passes |
| pass_start | input | 1 | Begins one evaluation pass when idle |
| in_flags | input | 16 | External operand flags |
| vout | output | 16 | Committed virtual outputs |
| busy | output | 1 | Pass in progress |
| pass_done | output | 1 | One-cycle pulse at pass end |
| err_flag | output | 1 | Sticky stack error flag |

## Verification
A single program that combines all operators is run 128 times. Six of the input flags step through every value, so AND, OR and XOR are tried at two, three and four operands on all sixteen operand patterns. This separates the operators from one another and catches a wrong operand count or a wrong stack position. The latch inputs go through every set/reset pair with hold periods between them, which exposes the priority and the retention. The timer input follows a repeating four-high, three-low pattern that shows off-by-one faults in the pickup and dropout counts. A feedback equation that reads a virtual output both before and after its assignment tells previous-pass values from same-pass values. Separate short programs drive the stack to exactly full and one past full, and also underflow it and leave it non-empty at the end. Together they show where errors start and that a faulty pass commits nothing.

// File: rtl/eqn_pkg.sv
package eqn_pkg;

  localparam logic [3:0] OP_END     = 4'd0;
  localparam logic [3:0] OP_PUSH_IN = 4'd1;
  localparam logic [3:0] OP_PUSH_VO = 4'd2;
  localparam logic [3:0] OP_NOT     = 4'd3;
  localparam logic [3:0] OP_AND     = 4'd4;
  localparam logic [3:0] OP_OR      = 4'd5;
  localparam logic [3:0] OP_XOR     = 4'd6;
  localparam logic [3:0] OP_LATCH   = 4'd7;
  localparam logic [3:0] OP_TIMER   = 4'd8;
  localparam logic [3:0] OP_ASSIGN  = 4'd9;

  typedef struct packed {
    logic [3:0] op;
    logic [3:0] cnt;
    logic [7:0] idx;
  } entry_t;

endpackage

// File: rtl/eqn_prog_mem.sv
module eqn_prog_mem
  import eqn_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  entry_t        wr_data,
  input  logic [AW-1:0] rd_addr,
  output entry_t        rd_data
);

  entry_t mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/eqn_stack_alu.sv
module eqn_stack_alu
  import eqn_pkg::*;
#(
  parameter int SDEPTH = 16,
  localparam int SPW = $clog2(SDEPTH + 1)
) (
  input  logic [3:0]        op,
  input  logic [3:0]        cnt,
  input  logic [SDEPTH-1:0] stk,
  input  logic [SPW-1:0]    sp,
  input  logic              ext_val,
  output logic [SDEPTH-1:0] stk_nxt,
  output logic [SPW-1:0]    sp_nxt,
  output logic              fault,
  output logic              top_bit,
  output logic              sec_bit
);

  int fill;
  int nops;
  assign fill = int'(sp);
  assign nops = int'(cnt);

  // operand taps, kept apart from the update logic
  always_comb begin
    top_bit = 1'b0;
    sec_bit = 1'b0;
    for (int i = 0; i < SDEPTH; i++) begin
      if (i + 1 == fill) top_bit = stk[i];
      if (i + 2 == fill) sec_bit = stk[i];
    end
  end

  logic and_r, or_r, xor_r, red_r;

  always_comb begin
    and_r = 1'b1;
    or_r  = 1'b0;
    xor_r = 1'b0;
    for (int i = 0; i < SDEPTH; i++) begin
      if (i >= fill - nops && i < fill) begin
        and_r = and_r & stk[i];
        or_r  = or_r | stk[i];
        xor_r = xor_r ^ stk[i];
      end
    end
    case (op)
      OP_AND:  red_r = and_r;
      OP_OR:   red_r = or_r;
      default: red_r = xor_r;
    endcase
  end

  always_comb begin
    stk_nxt = stk;
    sp_nxt  = sp;
    fault   = 1'b0;
    case (op)
      OP_PUSH_IN, OP_PUSH_VO: begin
        if (fill >= SDEPTH) fault = 1'b1;
        else begin
          for (int i = 0; i < SDEPTH; i++) if (i == fill) stk_nxt[i] = ext_val;
          sp_nxt = sp + 1'b1;
        end
      end
      OP_NOT: begin
        if (fill < 1) fault = 1'b1;
        else for (int i = 0; i < SDEPTH; i++) if (i + 1 == fill) stk_nxt[i] = ~stk[i];
      end
      OP_AND, OP_OR, OP_XOR: begin
        if (nops == 0 || fill < nops) fault = 1'b1;
        else begin
          for (int i = 0; i < SDEPTH; i++) if (i == fill - nops) stk_nxt[i] = red_r;
          sp_nxt = SPW'(fill - nops + 1);
        end
      end
      OP_LATCH: begin
        if (fill < 2) fault = 1'b1;
        else begin
          for (int i = 0; i < SDEPTH; i++) if (i + 2 == fill) stk_nxt[i] = ext_val;
          sp_nxt = sp - 1'b1;
        end
      end
      OP_TIMER: begin
        if (fill < 1) fault = 1'b1;
        else for (int i = 0; i < SDEPTH; i++) if (i + 1 == fill) stk_nxt[i] = ext_val;
      end
      OP_ASSIGN: begin
        if (fill < 1) fault = 1'b1;
        else sp_nxt = sp - 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/eqn_state_bank.sv
module eqn_state_bank #(
  parameter int N_LATCH = 8,
  parameter int N_TIMER = 8,
  parameter int TMR_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lat_en,
  input  logic             tmr_en,
  input  logic [7:0]       sel,
  input  logic             set_in,
  input  logic             clr_in,
  input  logic             tmr_in,
  input  logic             cfg_we,
  input  logic [7:0]       cfg_sel,
  input  logic [TMR_W-1:0] cfg_pick,
  input  logic [TMR_W-1:0] cfg_drop,
  output logic             lat_q_new,
  output logic             tmr_q_new
);

  // set/reset latches, reset dominant
  logic [N_LATCH-1:0] lat_q, lat_d;

  always_comb begin
    lat_q_new = 1'b0;
    lat_d     = lat_q;
    for (int i = 0; i < N_LATCH; i++) begin
      if (sel == 8'(i)) begin
        lat_q_new = clr_in ? 1'b0 : (set_in ? 1'b1 : lat_q[i]);
        if (lat_en) lat_d[i] = lat_q_new;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else        lat_q <= lat_d;
  end

  // pickup/dropout timers, one per instance
  logic [N_TIMER-1:0] tq_new;

  for (genvar g = 0; g < N_TIMER; g++) begin : g_tmr
    logic             q_q, q_d, q_n;
    logic [TMR_W-1:0] cnt_q, cnt_d, cnt_n;
    logic [TMR_W-1:0] pick_q, pick_d, drop_q, drop_d;
    logic [TMR_W-1:0] inc, lim;
    logic             hit, cfg_hit;

    assign hit     = tmr_en && (sel == 8'(g));
    assign cfg_hit = cfg_we && (cfg_sel == 8'(g));

    always_comb begin
      inc = cnt_q + 1'b1;
      lim = tmr_in ? pick_q : drop_q;
      if (tmr_in != q_q) begin
        if (inc >= lim) begin
          q_n   = tmr_in;
          cnt_n = '0;
        end else begin
          q_n   = q_q;
          cnt_n = inc;
        end
      end else begin
        q_n   = q_q;
        cnt_n = '0;
      end
      q_d    = hit ? q_n : q_q;
      cnt_d  = hit ? cnt_n : cnt_q;
      pick_d = cfg_hit ? cfg_pick : pick_q;
      drop_d = cfg_hit ? cfg_drop : drop_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_q    <= 1'b0;
        cnt_q  <= '0;
        pick_q <= '0;
        drop_q <= '0;
      end else begin
        q_q    <= q_d;
        cnt_q  <= cnt_d;
        pick_q <= pick_d;
        drop_q <= drop_d;
      end
    end

    assign tq_new[g] = q_n;
  end

  always_comb begin
    tmr_q_new = 1'b0;
    for (int i = 0; i < N_TIMER; i++) if (sel == 8'(i)) tmr_q_new = tq_new[i];
  end

endmodule

// File: rtl/logic_eqn_engine.sv
module logic_eqn_engine
  import eqn_pkg::*;
#(
  parameter int PROG_DEPTH  = 64,
  parameter int STACK_DEPTH = 16,
  parameter int N_IN        = 16,
  parameter int N_VO        = 16,
  parameter int N_LATCH     = 8,
  parameter int N_TIMER     = 8,
  parameter int TMR_W       = 8,
  localparam int PAW = $clog2(PROG_DEPTH),
  localparam int SPW = $clog2(STACK_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_we,
  input  logic [PAW-1:0]   prog_addr,
  input  logic [15:0]      prog_data,
  input  logic             tcfg_we,
  input  logic [7:0]       tcfg_sel,
  input  logic [TMR_W-1:0] tcfg_pickup,
  input  logic [TMR_W-1:0] tcfg_dropout,
  input  logic             pass_start,
  input  logic [N_IN-1:0]  in_flags,
  output logic [N_VO-1:0]  vout,
  output logic             busy,
  output logic             pass_done,
  output logic             err_flag
);

  // reset: asserted at once, released after two clocks
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic                   run_q, run_d;
  logic [PAW-1:0]         pc_q, pc_d;
  logic [SPW-1:0]         sp_q, sp_d;
  logic [STACK_DEPTH-1:0] stk_q, stk_d;
  logic [N_VO-1:0]        work_q, work_d;
  logic [N_VO-1:0]        vout_q, vout_d;
  logic                   done_q, done_d;
  logic                   err_q, err_d;
  logic                   bad_q, bad_d;

  entry_t ent;

  eqn_prog_mem #(.DEPTH(PROG_DEPTH)) u_mem (
    .clk     (clk),
    .wr_en   (prog_we),
    .wr_addr (prog_addr),
    .wr_data (entry_t'(prog_data)),
    .rd_addr (pc_q),
    .rd_data (ent)
  );

  logic is_end, exec, finish;
  logic [3:0] alu_op;
  assign is_end = run_q && (ent.op == OP_END);
  assign exec   = run_q && !is_end;
  assign finish = run_q && (is_end || pc_q == PAW'(PROG_DEPTH - 1));
  assign alu_op = exec ? ent.op : OP_END;

  logic [STACK_DEPTH-1:0] alu_stk;
  logic [SPW-1:0]         alu_sp;
  logic                   fault, top_bit, sec_bit, ext_val;
  logic                   lat_q_new, tmr_q_new;

  eqn_stack_alu #(.SDEPTH(STACK_DEPTH)) u_alu (
    .op      (alu_op),
    .cnt     (ent.cnt),
    .stk     (stk_q),
    .sp      (sp_q),
    .ext_val (ext_val),
    .stk_nxt (alu_stk),
    .sp_nxt  (alu_sp),
    .fault   (fault),
    .top_bit (top_bit),
    .sec_bit (sec_bit)
  );

  eqn_state_bank #(.N_LATCH(N_LATCH), .N_TIMER(N_TIMER), .TMR_W(TMR_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .lat_en    (alu_op == OP_LATCH && !fault),
    .tmr_en    (alu_op == OP_TIMER && !fault),
    .sel       (ent.idx),
    .set_in    (sec_bit),
    .clr_in    (top_bit),
    .tmr_in    (top_bit),
    .cfg_we    (tcfg_we),
    .cfg_sel   (tcfg_sel),
    .cfg_pick  (tcfg_pickup),
    .cfg_drop  (tcfg_dropout),
    .lat_q_new (lat_q_new),
    .tmr_q_new (tmr_q_new)
  );

  // operand source for the current entry
  always_comb begin
    ext_val = 1'b0;
    case (ent.op)
      OP_PUSH_IN: for (int i = 0; i < N_IN; i++) if (ent.idx == 8'(i)) ext_val = in_flags[i];
      OP_PUSH_VO: for (int i = 0; i < N_VO; i++) if (ent.idx == 8'(i)) ext_val = work_q[i];
      OP_LATCH:   ext_val = lat_q_new;
      OP_TIMER:   ext_val = tmr_q_new;
      default:    ext_val = 1'b0;
    endcase
  end

  // working copy after this entry's assignment
  logic [N_VO-1:0] work_nxt;
  always_comb begin
    work_nxt = work_q;
    if (alu_op == OP_ASSIGN && !fault)
      for (int i = 0; i < N_VO; i++) if (ent.idx == 8'(i)) work_nxt[i] = top_bit;
  end

  logic pass_bad;
  assign pass_bad = bad_q | fault | (alu_sp != '0);

  always_comb begin
    run_d  = run_q;
    pc_d   = pc_q;
    sp_d   = sp_q;
    stk_d  = stk_q;
    work_d = work_q;
    vout_d = vout_q;
    bad_d  = bad_q;
    done_d = 1'b0;
    err_d  = err_q;
    if (!run_q) begin
      if (pass_start) begin
        run_d  = 1'b1;
        pc_d   = '0;
        sp_d   = '0;
        bad_d  = 1'b0;
        work_d = vout_q;
      end
    end else begin
      pc_d   = pc_q + 1'b1;
      sp_d   = alu_sp;
      stk_d  = alu_stk;
      work_d = work_nxt;
      bad_d  = bad_q | fault;
      err_d  = err_q | fault;
      if (finish) begin
        run_d  = 1'b0;
        done_d = 1'b1;
        err_d  = err_q | pass_bad;
        if (!pass_bad) vout_d = work_nxt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      run_q  <= 1'b0;
      pc_q   <= '0;
      sp_q   <= '0;
      stk_q  <= '0;
      work_q <= '0;
      vout_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      run_q  <= run_d;
      pc_q   <= pc_d;
      sp_q   <= sp_d;
      stk_q  <= stk_d;
      work_q <= work_d;
      vout_q <= vout_d;
      done_q <= done_d;
      err_q  <= err_d;
      bad_q  <= bad_d;
    end
  end

  assign vout      = vout_q;
  assign busy      = run_q;
  assign pass_done = done_q;
  assign err_flag  = err_q;

endmodule

// File: rtl/logic_eqn_engine_chk.sv
module logic_eqn_engine_chk #(
  parameter int N_VO = 16
) (
  input logic            clk,
  input logic            arst_n,
  input logic            pass_start,
  input logic            busy,
  input logic            pass_done,
  input logic            err_flag,
  input logic [N_VO-1:0] vout
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!arst_n)
    pass_done |=> !pass_done); // R1

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!arst_n)
    pass_done |-> !busy); // R1

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!arst_n)
    (pass_start && !busy) |=> busy); // R1

  AST_VOUT_AT_DONE: assert property (@(posedge clk) disable iff (!arst_n)
    !$stable(vout) |-> pass_done); // R5

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!arst_n)
    err_flag |=> err_flag); // R9

  AST_ERR_HOLDS_VOUT: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(err_flag) |-> $stable(vout)); // R10

endmodule

bind logic_eqn_engine logic_eqn_engine_chk #(.N_VO(N_VO)) u_chk (
  .clk        (clk),
  .arst_n     (rst_sync_n),
  .pass_start (pass_start),
  .busy       (busy),
  .pass_done  (pass_done),
  .err_flag   (err_flag),
  .vout       (vout)
);

// File: tb/tb_logic_eqn_engine.sv
module tb_logic_eqn_engine;

  localparam logic [3:0] K_END = 4'd0, K_IN = 4'd1, K_VO = 4'd2, K_NOT = 4'd3,
                         K_AND = 4'd4, K_OR = 4'd5, K_XOR = 4'd6, K_LAT = 4'd7,
                         K_TMR = 4'd8, K_SET = 4'd9;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        prog_we;
  logic [5:0]  prog_addr;
  logic [15:0] prog_data;
  logic        tcfg_we;
  logic [7:0]  tcfg_sel, tcfg_pickup, tcfg_dropout;
  logic        pass_start;
  logic [15:0] in_flags;
  logic [15:0] vout;
  logic        busy, pass_done, err_flag;

  always #5 clk = ~clk;

  logic_eqn_engine dut (
    .clk (clk), .rst_n (rst_n),
    .prog_we (prog_we), .prog_addr (prog_addr), .prog_data (prog_data),
    .tcfg_we (tcfg_we), .tcfg_sel (tcfg_sel),
    .tcfg_pickup (tcfg_pickup), .tcfg_dropout (tcfg_dropout),
    .pass_start (pass_start), .in_flags (in_flags),
    .vout (vout), .busy (busy), .pass_done (pass_done), .err_flag (err_flag)
  );

  int n_chk = 0, n_bad = 0, cyc = 0, pa = 0, busy_cnt = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [3:0] op, input logic [3:0] cnt, input logic [7:0] idx);
    prog_we   = 1'b1;
    prog_addr = pa[5:0];
    prog_data = {op, cnt, idx};
    pa++;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic run_pass();
    @(negedge clk);
    pass_start = 1'b1;
    @(negedge clk);
    pass_start = 1'b0;
    busy_cnt = 0;
    for (int k = 0; k < 400; k++) begin
      if (busy) busy_cnt++;
      if (pass_done) break;
      @(negedge clk);
    end
    if (!pass_done) check("R1 pass finish", 0, 1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    while (cyc < 150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=finish", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] vref;
    logic [3:0]  a;
    logic        lq, tq, tin, prev8;
    int          tc, dones;

    prog_we = 0; prog_addr = 0; prog_data = 0;
    tcfg_we = 0; tcfg_sel = 0; tcfg_pickup = 0; tcfg_dropout = 0;
    pass_start = 0; in_flags = 0;
    do_reset();

    // R12 reset state
    check("R12 vout", vout, 0);
    check("R12 busy", busy, 0);
    check("R12 done", pass_done, 0);
    check("R12 err", err_flag, 0);

    // combined program, 53 entries including the end entry
    pa = 0;
    put(K_IN,0,0); put(K_IN,0,1); put(K_AND,2,0); put(K_SET,0,0);
    put(K_IN,0,0); put(K_IN,0,1); put(K_OR,2,0);  put(K_SET,0,1);
    put(K_IN,0,0); put(K_IN,0,1); put(K_XOR,2,0); put(K_SET,0,2);
    put(K_IN,0,0); put(K_NOT,0,0); put(K_SET,0,3);
    for (int g = 0; g < 3; g++) begin
      for (int b = 0; b < 4; b++) put(K_IN,0,8'(b));
      put(g == 0 ? K_OR : (g == 1 ? K_AND : K_XOR), 4, 0);
      put(K_SET,0,8'(4 + g));
    end
    put(K_IN,0,0); put(K_IN,0,1); put(K_IN,0,2); put(K_XOR,3,0); put(K_SET,0,7);
    put(K_VO,0,8); put(K_NOT,0,0); put(K_SET,0,9);
    put(K_IN,0,0); put(K_SET,0,8);
    put(K_VO,0,8); put(K_SET,0,10);
    put(K_IN,0,4); put(K_IN,0,5); put(K_LAT,0,0); put(K_SET,0,11);
    put(K_IN,0,6); put(K_TMR,0,0); put(K_SET,0,12);
    put(K_END,0,0);

    @(negedge clk);
    tcfg_we = 1; tcfg_sel = 0; tcfg_pickup = 8'd3; tcfg_dropout = 8'd2;
    @(negedge clk);
    tcfg_we = 0;

    vref = '0; lq = 0; tq = 0; tc = 0;
    for (int i = 0; i < 128; i++) begin
      tin = ((i % 7) < 4);
      in_flags = {9'b0, tin, 6'(i)};
      run_pass();
      if (i == 0) check("R1 busy cycles", busy_cnt, 53);
      a = 4'(i);
      prev8 = vref[8];
      vref[0] = a[0] & a[1];
      vref[1] = a[0] | a[1];
      vref[2] = a[0] ^ a[1];
      vref[3] = ~a[0];
      vref[4] = |a;
      vref[5] = &a;
      vref[6] = ^a;
      vref[7] = a[0] ^ a[1] ^ a[2];
      vref[9] = ~prev8;
      vref[8] = a[0];
      vref[10] = a[0];
      lq = in_flags[5] ? 1'b0 : (in_flags[4] ? 1'b1 : lq);
      vref[11] = lq;
      if (tin != tq) begin
        tc++;
        if (tc >= (tin ? 3 : 2)) begin tq = tin; tc = 0; end
      end else tc = 0;
      vref[12] = tq;
      check("R3 and/or/xor", {vout[7:4], vout[2:0]}, {vref[7:4], vref[2:0]});
      check("R4 not", vout[3], vref[3]);
      check("R2 R6 feedback", vout[10:8], vref[10:8]);
      check("R7 latch", vout[11], lq);
      check("R8 timer", vout[12], tq);
      check("R5 unused outputs", vout[15:13], 0);
    end

    // R11 / R5: second strobe mid-pass, outputs held until done
    in_flags = 16'h0000;
    @(negedge clk);
    pass_start = 1;
    @(negedge clk);
    pass_start = 0;
    repeat (5) @(negedge clk);
    pass_start = 1;
    check("R5 vout held mid-pass", vout, vref);
    @(negedge clk);
    pass_start = 0;
    dones = 0;
    for (int k = 0; k < 150; k++) begin
      if (pass_done) dones++;
      @(negedge clk);
    end
    check("R11 one pass only", dones, 1);
    check("R5 committed after done", vout[3:0], 4'b1000);

    // R9 / R10 non-empty stack at end
    do_reset();
    in_flags = 16'h0001;
    pa = 0;
    put(K_IN,0,0); put(K_SET,0,0); put(K_IN,0,0); put(K_END,0,0);
    run_pass();
    check("R9 leftover sets err", err_flag, 1);
    check("R10 leftover no commit", vout, 0);
    pa = 0;
    put(K_IN,0,0); put(K_SET,0,0); put(K_END,0,0);
    run_pass();
    check("R9 err sticky", err_flag, 1);
    check("R10 clean pass commits", vout, 16'h0001);

    // R9 underflow
    do_reset();
    pa = 0;
    put(K_IN,0,0); put(K_OR,2,0); put(K_SET,0,1); put(K_END,0,0);
    run_pass();
    check("R9 underflow err", err_flag, 1);
    check("R10 underflow no commit", vout, 0);

    // R9 count zero
    do_reset();
    pa = 0;
    put(K_IN,0,0); put(K_AND,0,0); put(K_SET,0,0); put(K_END,0,0);
    run_pass();
    check("R9 count zero err", err_flag, 1);
    check("R10 count zero no commit", vout, 0);

    // R9 exactly full stack is legal
    do_reset();
    pa = 0;
    for (int k = 0; k < 16; k++) put(K_IN,0,0);
    put(K_OR,15,0); put(K_OR,2,0); put(K_SET,0,0); put(K_END,0,0);
    run_pass();
    check("R9 full stack no err", err_flag, 0);
    check("R3 deep OR result", vout, 16'h0001);
    check("R1 busy cycles deep", busy_cnt, 20);

    // R9 one push beyond full
    do_reset();
    pa = 0;
    for (int k = 0; k < 17; k++) put(K_IN,0,0);
    put(K_OR,15,0); put(K_OR,2,0); put(K_SET,0,0); put(K_END,0,0);
    run_pass();
    check("R9 overflow err", err_flag, 1);
    check("R10 overflow no commit", vout, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule